// File: doc/BRIEF.md
# SRAM Retention Sequencer

This block steps an embedded SRAM macro between four power conditions: fully active, standby, retention with both supplies on, and retention with the periphery supply removed. It drives the macro's active-low chip enable, its active-low retention control, an enable for the macro clock gate, and enables for the periphery and core supply domains. A system power manager asks for low-power retention with a one-cycle sleep request and asks for wake-up with a one-cycle wake request. Ordinary memory traffic asks for access through an access request and gets a grant back.

On the way into retention the sequencer first deselects the macro. It then stops the macro clock and only then lowers the retention control. The periphery supply is cut last. Exit runs the same steps in reverse. Every step is held for a settle interval of `SETTLE_CYCLES` clocks, so the macro pins and the analog supply switches have time to respond. A wake request that arrives while entry is still running is remembered and served once retention has been fully reached. No step is cut short.

Top module: `sram_ret_seq`

## Requirements
- R1: After the active-low reset `rst_ni` is asserted, the outputs show the active state: `ready_o`=1, `busy_o`=0, `mem_clk_en_o`=1, `mem_ret_no`=1, `periph_pwr_en_o`=1, `core_pwr_en_o`=1. With no access request, `mem_ce_no`=1 and `acc_gnt_o`=0. Reset is asynchronous.
- R2: In the active state, `acc_req_i`=1 gives `acc_gnt_o`=1 and `mem_ce_no`=0 in the same cycle. The path from request to grant is combinational.
- R3: A `sleep_req_i` sampled in the active state starts entry at that clock edge. The steps take place in this order, and each lasts `SETTLE_CYCLES` edges:
  - standby: chip enable high, clock still running;
  - clock gated;
  - retention control low;
  - periphery supply off.
  The retained state is reached `4*SETTLE_CYCLES` edges after the request edge.
- R4: The retention control only changes while the clock gate is closed. It was also closed in the cycle before the change.
- R5: The periphery supply is off only while the retention control is low. `core_pwr_en_o` stays high in every state.
- R6: Outside the active state, `acc_gnt_o`=0 and `mem_ce_no`=1, whatever the value of `acc_req_i`.
- R7: A `wake_req_i` sampled in the retained state starts exit. The periphery supply comes on for `SETTLE_CYCLES` edges, with the retention control still low and the clock gated. The retention control then rises and is held high for `SETTLE_CYCLES` edges, with the clock still gated. After that the active state returns.
- R8: A wake request during any entry step is held and does not shorten entry. The retained state is shown for exactly one cycle, and exit then starts without a further request.
- R9: `ready_o` is high only in the active state. `busy_o` is high in every entry and exit step, and low in the active and retained states.
- R10: A wake request in the active state has no effect. A sleep request in the retained state or during exit has no effect.
- R11: With the default parameter, `SETTLE_CYCLES` is 200. The standby step lasts 200 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_req_i | input | 1 | Request to enter retention |
| wake_req_i | input | 1 | Request to leave retention |
| acc_req_i | input | 1 | Memory access request |
| acc_gnt_o | output | 1 | Access granted this cycle |
| mem_ce_no | output | 1 | Macro chip enable, active low |
| mem_ret_no | output | 1 | Macro retention control, active low |
| mem_clk_en_o | output | 1 | Enable for the macro clock gate |
| periph_pwr_en_o | output | 1 | Periphery supply domain enable |
| core_pwr_en_o | output | 1 | Core array supply domain enable |
| ready_o | output | 1 | Macro usable for accesses |
| busy_o | output | 1 | Entry or exit sequence in progress |

## Verification
The bench samples the last edge and the first edge of each settle step. An off-by-one in the settle counter would therefore show up as a step that is one cycle long or one cycle short. It holds an access request through entry, so a grant leaking out of standby or retention would be seen. A wake pulse early in entry checks that the request is held. A design that dropped the pulse would stay in retention, and one that acted on it at once would skip steps or turn the periphery supply back on too soon. Stray sleep requests during retention and exit, and a stray wake request while active, must leave every output unchanged. A reset in the middle of entry must return the macro to the active state at once.

// File: rtl/sram_ret_pkg.sv
package sram_ret_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE   = 3'd0,
        ST_STBY     = 3'd1,
        ST_CLKOFF   = 3'd2,
        ST_RETLO    = 3'd3,
        ST_PGOFF    = 3'd4,
        ST_RETAINED = 3'd5,
        ST_PWRON    = 3'd6,
        ST_RETHI    = 3'd7
    } ret_state_e;

    typedef struct packed {
        ret_state_e state;
        logic       wake_pend;
    } seq_regs_t;

    typedef struct packed {
        logic ce_n;
        logic ret_n;
        logic clk_en;
        logic peri_en;
        logic core_en;
        logic ready;
        logic busy;
        logic gnt;
    } macro_ctl_t;

    function automatic logic is_entry(ret_state_e s);
        return (s == ST_STBY) || (s == ST_CLKOFF) ||
               (s == ST_RETLO) || (s == ST_PGOFF);
    endfunction

endpackage

// File: rtl/sram_ret_timer.sv
module sram_ret_timer #(
    parameter int SETTLE_CYCLES = 200,
    localparam int CW = $clog2(SETTLE_CYCLES) + 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic expired_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    // A start loads the count; the owning state then lasts SETTLE_CYCLES edges.
    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = CW'(SETTLE_CYCLES - 1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/sram_ret_decode.sv
module sram_ret_decode
    import sram_ret_pkg::*;
(
    input  ret_state_e state_i,
    input  logic       acc_req_i,
    output macro_ctl_t ctl_o
);

    always_comb begin
        ctl_o         = '0;
        ctl_o.core_en = 1'b1;
        ctl_o.ce_n    = 1'b1;
        unique case (state_i)
            ST_ACTIVE: begin
                ctl_o.ret_n   = 1'b1;
                ctl_o.clk_en  = 1'b1;
                ctl_o.peri_en = 1'b1;
                ctl_o.ready   = 1'b1;
                ctl_o.gnt     = acc_req_i;
                ctl_o.ce_n    = ~acc_req_i;
            end
            ST_STBY: begin
                ctl_o.ret_n   = 1'b1;
                ctl_o.clk_en  = 1'b1;
                ctl_o.peri_en = 1'b1;
                ctl_o.busy    = 1'b1;
            end
            ST_CLKOFF, ST_RETHI: begin
                ctl_o.ret_n   = 1'b1;
                ctl_o.peri_en = 1'b1;
                ctl_o.busy    = 1'b1;
            end
            ST_RETLO, ST_PWRON: begin
                ctl_o.peri_en = 1'b1;
                ctl_o.busy    = 1'b1;
            end
            ST_PGOFF: begin
                ctl_o.busy    = 1'b1;
            end
            ST_RETAINED: begin
                ctl_o.busy    = 1'b0;
            end
            default: begin
                ctl_o.busy    = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/sram_ret_seq.sv
module sram_ret_seq
    import sram_ret_pkg::*;
#(
    parameter int SETTLE_CYCLES = 200
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sleep_req_i,
    input  logic wake_req_i,
    input  logic acc_req_i,
    output logic acc_gnt_o,
    output logic mem_ce_no,
    output logic mem_ret_no,
    output logic mem_clk_en_o,
    output logic periph_pwr_en_o,
    output logic core_pwr_en_o,
    output logic ready_o,
    output logic busy_o
);

    seq_regs_t  r_d, r_q;
    logic       tmr_start;
    logic       tmr_expired;
    macro_ctl_t ctl;

    sram_ret_timer #(
        .SETTLE_CYCLES(SETTLE_CYCLES)
    ) u_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (tmr_start),
        .expired_o(tmr_expired)
    );

    always_comb begin
        r_d       = r_q;
        tmr_start = 1'b0;
        unique case (r_q.state)
            ST_ACTIVE: if (sleep_req_i) begin
                r_d.state = ST_STBY;
                tmr_start = 1'b1;
            end
            ST_STBY: if (tmr_expired) begin
                r_d.state = ST_CLKOFF;
                tmr_start = 1'b1;
            end
            ST_CLKOFF: if (tmr_expired) begin
                r_d.state = ST_RETLO;
                tmr_start = 1'b1;
            end
            ST_RETLO: if (tmr_expired) begin
                r_d.state = ST_PGOFF;
                tmr_start = 1'b1;
            end
            ST_PGOFF: if (tmr_expired) begin
                r_d.state = ST_RETAINED;
            end
            ST_RETAINED: if (wake_req_i || r_q.wake_pend) begin
                r_d.state     = ST_PWRON;
                r_d.wake_pend = 1'b0;
                tmr_start     = 1'b1;
            end
            ST_PWRON: if (tmr_expired) begin
                r_d.state = ST_RETHI;
                tmr_start = 1'b1;
            end
            ST_RETHI: if (tmr_expired) begin
                r_d.state = ST_ACTIVE;
            end
            default: r_d.state = ST_ACTIVE;
        endcase
        // Wake seen mid-entry is remembered until retention is reached.
        if (is_entry(r_q.state) && wake_req_i) begin
            r_d.wake_pend = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.state     <= ST_ACTIVE;
            r_q.wake_pend <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    sram_ret_decode u_decode (
        .state_i  (r_q.state),
        .acc_req_i(acc_req_i),
        .ctl_o    (ctl)
    );

    assign acc_gnt_o       = ctl.gnt;
    assign mem_ce_no       = ctl.ce_n;
    assign mem_ret_no      = ctl.ret_n;
    assign mem_clk_en_o    = ctl.clk_en;
    assign periph_pwr_en_o = ctl.peri_en;
    assign core_pwr_en_o   = ctl.core_en;
    assign ready_o         = ctl.ready;
    assign busy_o          = ctl.busy;

endmodule

// File: rtl/sram_ret_seq_chk.sv
module sram_ret_seq_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic acc_gnt_o,
    input logic mem_ce_no,
    input logic mem_ret_no,
    input logic mem_clk_en_o,
    input logic periph_pwr_en_o,
    input logic ready_o,
    input logic busy_o
);

    AST_RET_NEEDS_STANDBY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mem_ret_no |-> mem_ce_no);  // R3

    AST_RET_EDGE_CLOCK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_ret_no != $past(mem_ret_no)) |-> (!mem_clk_en_o && !$past(mem_clk_en_o)));  // R4

    AST_PERI_OFF_IN_RET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !periph_pwr_en_o |-> !mem_ret_no);  // R5

    AST_NO_GRANT_OFF_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_gnt_o |-> (ready_o && mem_clk_en_o && mem_ret_no && !mem_ce_no));  // R6

    AST_RET_RISE_AFTER_PERI: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mem_ret_no) |-> (periph_pwr_en_o && $past(periph_pwr_en_o)));  // R7

    AST_READY_BUSY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ready_o && busy_o));  // R9

endmodule

bind sram_ret_seq sram_ret_seq_chk u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .acc_gnt_o      (acc_gnt_o),
    .mem_ce_no      (mem_ce_no),
    .mem_ret_no     (mem_ret_no),
    .mem_clk_en_o   (mem_clk_en_o),
    .periph_pwr_en_o(periph_pwr_en_o),
    .ready_o        (ready_o),
    .busy_o         (busy_o)
);

// File: tb/sim_sram_ret_seq.sv
module sim_sram_ret_seq;

    localparam int S = 12;

    // Expected bundle: {ce_n, ret_n, clk_en, peri, ready, busy, gnt}
    localparam logic [6:0] E_ACT  = 7'b1111100;
    localparam logic [6:0] E_ACTG = 7'b0111101;
    localparam logic [6:0] E_STBY = 7'b1111010;
    localparam logic [6:0] E_CLKO = 7'b1101010;
    localparam logic [6:0] E_RETL = 7'b1001010;
    localparam logic [6:0] E_PGOF = 7'b1000010;
    localparam logic [6:0] E_RETD = 7'b1000000;

    // Vector: {sleep, wake, acc, edges[7:0], expected[6:0]}
    localparam int NV = 13;
    localparam logic [17:0] VEC [NV] = '{
        {3'b001, 8'd1,  E_ACTG},  // R2 grant while active
        {3'b010, 8'd1,  E_ACT },  // R10 wake in active ignored
        {3'b101, 8'd1,  E_STBY},  // R3 R6 standby, access blocked
        {3'b000, 8'd12, E_CLKO},  // R3 clock gated at S
        {3'b001, 8'd12, E_RETL},  // R3 R6 retention low at 2S
        {3'b000, 8'd12, E_PGOF},  // R3 R5 periphery off at 3S
        {3'b000, 8'd12, E_RETD},  // R3 R9 retained at 4S
        {3'b100, 8'd5,  E_RETD},  // R10 sleep in retention ignored
        {3'b010, 8'd1,  E_RETL},  // R7 periphery back on
        {3'b000, 8'd11, E_RETL},  // R7 still powering up
        {3'b100, 8'd1,  E_CLKO},  // R7 R10 retention high, sleep ignored
        {3'b000, 8'd11, E_CLKO},  // R7 clock still gated
        {3'b001, 8'd1,  E_ACTG}   // R7 R9 ready again
    };

    function automatic string vtag(int i);
        case (i)
            0:       return "R2";
            1:       return "R10";
            2, 4:    return "R6";
            3, 6:    return "R3";
            5:       return "R5";
            7, 10:   return "R10";
            default: return "R7";
        endcase
    endfunction

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep = 1'b0, wake = 1'b0, acc = 1'b0;
    logic dsleep = 1'b0;
    logic gnt, ce_n, ret_n, clk_en, peri, core, rdy, busy;
    logic d_gnt, d_ce_n, d_ret_n, d_clk_en, d_peri, d_core, d_rdy, d_busy;
    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    sram_ret_seq #(.SETTLE_CYCLES(S)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep), .wake_req_i(wake),
        .acc_req_i(acc), .acc_gnt_o(gnt), .mem_ce_no(ce_n), .mem_ret_no(ret_n),
        .mem_clk_en_o(clk_en), .periph_pwr_en_o(peri), .core_pwr_en_o(core),
        .ready_o(rdy), .busy_o(busy)
    );

    sram_ret_seq u_dflt (
        .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(dsleep), .wake_req_i(1'b0),
        .acc_req_i(1'b0), .acc_gnt_o(d_gnt), .mem_ce_no(d_ce_n), .mem_ret_no(d_ret_n),
        .mem_clk_en_o(d_clk_en), .periph_pwr_en_o(d_peri), .core_pwr_en_o(d_core),
        .ready_o(d_rdy), .busy_o(d_busy)
    );

    task automatic check(logic [6:0] exp, string tag);
        logic [7:0] act;
        act = {core, ce_n, ret_n, clk_en, peri, rdy, busy, gnt};
        nchk++;
        if (act !== {1'b1, exp}) begin
            nfail++;
            $display("FAIL %s actual=%b expected=%b (core,ce_n,ret_n,clk_en,peri,ready,busy,gnt)",
                     tag, act, {1'b1, exp});
        end
    endtask

    // Caller is at a falling edge; drives inputs, pulses sleep/wake for one edge.
    task automatic step(logic s, logic w, logic a, int edges);
        sleep = s; wake = w; acc = a;
        @(posedge clk);
        #1;
        sleep = 1'b0; wake = 1'b0;
        repeat (edges - 1) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #1;
        check(E_ACT, "R1 in reset");
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(E_ACT, "R1 after reset");

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][17], VEC[i][16], VEC[i][15], int'(VEC[i][14:7]));
            check(VEC[i][6:0], $sformatf("%s vector %0d", vtag(i), i));
        end

        // R8: wake during entry is held, entry runs in full
        step(1'b1, 1'b0, 1'b0, 1);  check(E_STBY, "R8 entry start");
        step(1'b0, 1'b0, 1'b0, 2);
        step(1'b0, 1'b1, 1'b0, 1);  check(E_STBY, "R8 wake at edge 3 no skip");
        step(1'b0, 1'b0, 1'b0, 17); check(E_CLKO, "R8 edge 20 clock gated");
        step(1'b0, 1'b0, 1'b0, 27); check(E_PGOF, "R8 edge 47 periphery off");
        step(1'b0, 1'b0, 1'b0, 1);  check(E_RETD, "R8 retained one cycle");
        step(1'b0, 1'b0, 1'b0, 1);  check(E_RETL, "R8 exit without new wake");
        step(1'b0, 1'b0, 1'b0, 12); check(E_CLKO, "R8 retention high");
        step(1'b0, 1'b0, 1'b1, 12); check(E_ACTG, "R8 active again");

        // R1: reset in the middle of entry
        step(1'b1, 1'b0, 1'b0, 30); check(E_RETL, "R3 edge 29 retention low");
        rst_n = 1'b0;
        #1;
        check(E_ACT, "R1 async reset mid-entry");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(E_ACT, "R1 active after reset release");

        // R11: default settle length of 200 on the default instance
        dsleep = 1'b1;
        @(posedge clk);
        #1;
        dsleep = 1'b0;
        repeat (199) @(posedge clk);
        @(negedge clk);
        nchk++;
        if (!(d_clk_en === 1'b1 && d_ce_n === 1'b1 && d_busy === 1'b1)) begin
            nfail++;
            $display("FAIL R11 edge 199 actual clk_en=%b ce_n=%b busy=%b expected 1 1 1",
                     d_clk_en, d_ce_n, d_busy);
        end
        @(negedge clk);
        nchk++;
        if (d_clk_en !== 1'b0) begin
            nfail++;
            $display("FAIL R11 edge 200 actual clk_en=%b expected 0", d_clk_en);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule